// File: doc/BRIEF.md
# Handshake Acknowledge Deadline Monitor

This block watches a two-wire request/acknowledge handshake and flags the first time an acknowledge arrives too late. A request opens a window of `LIMIT` cycles, and the acknowledge must be sampled within that window. The monitor is built as a small extended state machine. It has four control states: idle, answer pending, don't-care and violation. A single elapsed-cycle counter carries the timing. Each transition is selected by a guard on that counter and applies an action to it (clear, increment or hold), so no chain of per-cycle states is needed.

Only one request can be outstanding at a time. When the window expires without an acknowledge, the monitor raises a violation flag and a reason code, and both stay set until reset. An acknowledge that arrives while nothing is pending is an input combination the handshake does not define. The monitor steps through its don't-care state for that cycle, does not report it, and keeps checking later requests.

Top module: `hs_timeout_mon`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `viol_o` is 0 and `reason_o` is 2'b00.
- R2: A request sampled together with an acknowledge in the same cycle completes at once, opens no window and is never flagged.
- R3: If the acknowledge is sampled d cycles after the request cycle, with 1 <= d <= LIMIT, no violation is reported.
- R4: If no acknowledge is sampled in any of the LIMIT cycles after the request cycle, `viol_o` rises exactly at the clock edge that samples the LIMIT-th cycle, and not one cycle earlier.
- R5: `reason_o` is 2'b01 (acknowledge deadline missed) whenever `viol_o` is 1, and 2'b00 whenever `viol_o` is 0.
- R6: Once set, `viol_o` and `reason_o` keep their values for every combination of `req_i` and `ack_i` until `rst` is asserted.
- R7: An acknowledge with no request pending and no request in the same cycle is not flagged. A request in the very next cycle or later is then timed normally, from its own request cycle.
- R8: While a request is pending, further `req_i` pulses are ignored. The deadline stays measured from the first request cycle, so the flag rises at the same edge as it would without the extra pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request; sampled as a new request whenever none is pending |
| ack_i | input | 1 | Acknowledge for the pending request |
| viol_o | output | 1 | Sticky deadline violation flag |
| reason_o | output | 2 | Reason code: 2'b00 none, 2'b01 acknowledge deadline missed |

## Verification
The bench sweeps the acknowledge delay from zero through three cycles past the bound. It runs the sweep on a default-bound instance and on a short-bound instance together, and samples the flag after every edge, not only at the end. This catches an off-by-one in the guard: a design that compares against LIMIT-1 flags a legal acknowledge at delay LIMIT, and one that compares against LIMIT+1 raises the flag an edge late. The other targeted cases are these:
- Extra request pulses during a pending window; a design that restarts the counter on them misses the deadline.
- A stray acknowledge while idle; a design that reports it raises a false flag, and one that stays stuck in the don't-care state misses later violations.
- A barrage of inputs after a violation; a design that forgets the flag drops it before reset.

// File: rtl/hs_timeout_pkg.sv
package hs_timeout_pkg;

    // Control states of the extended state machine.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ANS  = 2'd1,
        ST_DC   = 2'd2,
        ST_VIO  = 2'd3
    } mon_state_e;

    // Reported reason codes.
    typedef enum logic [1:0] {
        RSN_NONE     = 2'd0,
        RSN_ACK_LATE = 2'd1
    } reason_e;

    // Action applied to the elapsed-cycle variable on a transition.
    typedef enum logic [1:0] {
        OP_CLR  = 2'd0,
        OP_INC  = 2'd1,
        OP_HOLD = 2'd2
    } cnt_op_e;

    typedef struct packed {
        mon_state_e nxt;
        cnt_op_e    op;
    } step_t;

    // One transition: current state, inputs and the guard predicate
    // (counter has reached the bound) select next state and counter action.
    function automatic step_t mon_step(mon_state_e cur, logic req,
                                       logic ack, logic at_bound);
        step_t s;
        s.nxt = cur;
        s.op  = OP_HOLD;
        unique case (cur)
            ST_IDLE, ST_DC: begin
                if (req && !ack) begin
                    s.nxt = ST_ANS;
                    s.op  = OP_INC;
                end else if (ack && !req) begin
                    s.nxt = ST_DC;
                    s.op  = OP_CLR;
                end else begin
                    s.nxt = ST_IDLE;
                    s.op  = OP_CLR;
                end
            end
            ST_ANS: begin
                if (ack) begin
                    s.nxt = ST_IDLE;
                    s.op  = OP_CLR;
                end else if (at_bound) begin
                    s.nxt = ST_VIO;
                    s.op  = OP_HOLD;
                end else begin
                    s.nxt = ST_ANS;
                    s.op  = OP_INC;
                end
            end
            default: begin
                s.nxt = ST_VIO;
                s.op  = OP_HOLD;
            end
        endcase
        return s;
    endfunction

    function automatic reason_e reason_of(mon_state_e st);
        return (st == ST_VIO) ? RSN_ACK_LATE : RSN_NONE;
    endfunction

endpackage

// File: rtl/hs_timeout_cnt.sv
module hs_timeout_cnt
    import hs_timeout_pkg::*;
#(
    parameter int LIMIT = 16,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_bound
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                OP_CLR:  cnt_q <= '0;
                OP_INC:  cnt_q <= cnt_q + CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Guard predicate used by the answer-state transitions.
    assign at_bound = (cnt_q == CNT_W'(LIMIT));

endmodule

// File: rtl/hs_timeout_ctrl.sv
module hs_timeout_ctrl
    import hs_timeout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       ack_i,
    input  logic       at_bound,
    output cnt_op_e    op,
    output mon_state_e nxt
);

    mon_state_e state_q;
    step_t      step;

    always_comb begin
        step = mon_step(state_q, req_i, ack_i, at_bound);
        op   = step.op;
        nxt  = step.nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= step.nxt;
    end

endmodule

// File: rtl/hs_timeout_flag.sv
module hs_timeout_flag
    import hs_timeout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mon_state_e nxt,
    output logic       viol_o,
    output logic [1:0] reason_o
);

    logic    viol_q;
    reason_e reason_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q   <= 1'b0;
            reason_q <= RSN_NONE;
        end else if (!viol_q) begin
            viol_q   <= (nxt == ST_VIO);
            reason_q <= reason_of(nxt);
        end
    end

    assign viol_o   = viol_q;
    assign reason_o = reason_q;

endmodule

// File: rtl/hs_timeout_mon.sv
module hs_timeout_mon
    import hs_timeout_pkg::*;
#(
    parameter int LIMIT = 16,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       ack_i,
    output logic       viol_o,
    output logic [1:0] reason_o
);

    cnt_op_e          op;
    mon_state_e       nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             at_bound;

    hs_timeout_cnt #(.LIMIT(LIMIT)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .cnt_q    (cnt_q),
        .at_bound (at_bound)
    );

    hs_timeout_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .ack_i    (ack_i),
        .at_bound (at_bound),
        .op       (op),
        .nxt      (nxt)
    );

    hs_timeout_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .nxt      (nxt),
        .viol_o   (viol_o),
        .reason_o (reason_o)
    );

endmodule

// File: rtl/hs_timeout_chk.sv
module hs_timeout_chk #(
    parameter int LIMIT = 16,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_i,
    input logic             ack_i,
    input logic             viol_o,
    input logic [1:0]       reason_o,
    input logic [CNT_W-1:0] cnt
);

    // Independent port-level model of the pending window.
    logic           pend_q;
    logic [CNT_W:0] age_q;
    logic           due;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            age_q  <= '0;
        end else if (!viol_o) begin
            if (!pend_q) begin
                if (req_i && !ack_i) begin
                    pend_q <= 1'b1;
                    age_q  <= (CNT_W+1)'(1);
                end
            end else if (ack_i) begin
                pend_q <= 1'b0;
                age_q  <= '0;
            end else begin
                age_q <= age_q + (CNT_W+1)'(1);
            end
        end
    end

    assign due = pend_q && !ack_i && (age_q == (CNT_W+1)'(LIMIT));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!viol_o && reason_o == 2'd0));

    assert_no_early_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (!viol_o && !due) |=> !viol_o);

    assert_flag_on_deadline_R4: assert property (@(posedge clk) disable iff (rst)
        (!viol_o && due) |=> viol_o);

    assert_reason_set_R5: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (reason_o == 2'd1));

    assert_reason_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !viol_o |-> (reason_o == 2'd0));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        viol_o |=> (viol_o && $stable(reason_o)));

    assert_idle_count_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !viol_o) |-> (cnt == '0));

    assert_count_tracks_age_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !viol_o) |-> ((CNT_W+1)'(cnt) == age_q));

endmodule

bind hs_timeout_mon hs_timeout_chk #(.LIMIT(LIMIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .ack_i    (ack_i),
    .viol_o   (viol_o),
    .reason_o (reason_o),
    .cnt      (cnt_q)
);

// File: tb/hs_timeout_mon_tb.sv
module hs_timeout_mon_tb;

    localparam int BIG   = 16;
    localparam int SMALL = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       ack = 1'b0;
    logic       vb, vs;
    logic [1:0] rb, rs;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hs_timeout_mon u_dut (
        .clk(clk), .rst(rst), .req_i(req), .ack_i(ack),
        .viol_o(vb), .reason_o(rb)
    );

    hs_timeout_mon #(.LIMIT(SMALL)) u_dut_s (
        .clk(clk), .rst(rst), .req_i(req), .ack_i(ack),
        .viol_o(vs), .reason_o(rs)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Checks both instances' flag and reason against expected flags.
    task automatic chk_both(string tag, bit eb, bit es);
        chk({tag, " big viol"},   int'(vb), int'(eb));
        chk({tag, " small viol"}, int'(vs), int'(es));
        chk("R5 big reason",      int'(rb), eb ? 1 : 0);
        chk("R5 small reason",    int'(rs), es ? 1 : 0);
    endtask

    // Ends at a negedge with rst low; values reflect the post-reset edge.
    task automatic do_reset();
        rst = 1'b1; req = 1'b0; ack = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_both("R1 in reset", 1'b0, 1'b0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk_both("R1 after reset", 1'b0, 1'b0);
        @(negedge clk);
    endtask

    // One request, acknowledge d cycles after the request cycle (d=0: same cycle).
    task automatic trial(int d);
        string tb_tag, ts_tag;
        do_reset();
        req = 1'b1; ack = (d == 0);
        @(posedge clk); @(negedge clk);
        req = 1'b0; ack = 1'b0;
        tb_tag = (d == 0) ? "R2" : (d <= BIG)   ? "R3" : "R4";
        ts_tag = (d == 0) ? "R2" : (d <= SMALL) ? "R3" : "R4";
        for (int j = 1; j <= BIG + 3; j++) begin
            ack = (j == d);
            @(posedge clk); #1;
            chk({tb_tag, " sweep big viol"},   int'(vb), int'((d > BIG)   && (j >= BIG)));
            chk({ts_tag, " sweep small viol"}, int'(vs), int'((d > SMALL) && (j >= SMALL)));
            chk("R5 sweep big reason",   int'(rb), ((d > BIG)   && (j >= BIG))   ? 1 : 0);
            chk("R5 sweep small reason", int'(rs), ((d > SMALL) && (j >= SMALL)) ? 1 : 0);
            @(negedge clk);
        end
        ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R2, R3, R4: delay sweep over both bounds.
        for (int d = 0; d <= BIG + 3; d++) trial(d);

        // R6: after the last trial both instances are flagged; hammer inputs.
        for (int k = 0; k < 8; k++) begin
            req = k[0]; ack = k[1];
            @(posedge clk); #1;
            chk_both("R6 sticky", 1'b1, 1'b1);
            @(negedge clk);
        end
        do_reset();

        // R7: stray acknowledges, then a request in the next cycle, acked at 3.
        ack = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk_both("R7 stray ack", 1'b0, 1'b0);
            @(negedge clk);
        end
        ack = 1'b0; req = 1'b1;
        @(posedge clk); @(negedge clk);
        req = 1'b0;
        for (int j = 1; j <= BIG + 2; j++) begin
            ack = (j == 3);
            @(posedge clk); #1;
            chk_both("R7 after dc", 1'b0, 1'b0);
            @(negedge clk);
        end
        // R7: a later unanswered request is still caught, right after a stray ack.
        ack = 1'b1;
        @(posedge clk); @(negedge clk);
        ack = 1'b0; req = 1'b1;
        @(posedge clk); @(negedge clk);
        req = 1'b0;
        for (int j = 1; j <= BIG + 1; j++) begin
            @(posedge clk); #1;
            chk_both("R7 resume", j >= BIG, j >= SMALL);
            @(negedge clk);
        end

        // R8: extra request pulses do not restart the window.
        do_reset();
        req = 1'b1;
        @(posedge clk); @(negedge clk);
        req = 1'b0;
        for (int j = 1; j <= BIG + 2; j++) begin
            req = (j == 2) || (j == 10);
            ack = (j == BIG + 1);
            @(posedge clk); #1;
            chk_both("R8 repeat req", j >= BIG, j >= SMALL);
            @(negedge clk);
        end
        req = 1'b0; ack = 1'b0;

        // R1: reset clears a set flag.
        do_reset();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule